// File: doc/BRIEF.md
# Fast Missing-Clock Holdover Trigger

This block sits next to the phase locked loop and watches the reference clock that is currently selected. It runs in the system clock domain and takes one single-cycle pulse per reference edge, which an upstream synchronizer has already made safe. A counter measures the time since the last edge. When that gap grows past roughly two expected reference periods, the block asks the loop to freeze in holdover. This isolates the loop from the failing input long before the slow quality monitor can reach a verdict.

While holdover is requested, the block keeps watching the same input. If edges come back and the slow monitor has not rejected the source, the first edge lifts the request. The loop then keeps tracking the same reference, with no reselection and no new acquisition. If the slow monitor's rejection alarm is set, edges no longer release the request, and the decision passes to the selection logic.

Every entry into holdover is recorded in a sticky failure bit that software clears by writing one. A phase-lost output can mirror the holdover request when an enable bit asks for it.

Top module: `refclk_gap_guard`

## Requirements
- R1: After reset, `holdover_req`, `main_ref_failed` and `phase_lost` are 0, and the gap counter starts from zero.
- R2: Let L = 2*`exp_period` + MARGIN, with MARGIN = 2 by default. Suppose a reference pulse is sampled at one clock edge and no pulse is sampled after it. Then `holdover_req` becomes 1 at the (L+2)-th clock edge after that edge, and not before.
- R3: Reference pulses spaced L+2 clock edges apart or closer never raise `holdover_req`. A pulse sampled at the same edge where the counter is over the limit also prevents the trip.
- R4: `main_ref_failed` becomes 1 at the edge where `holdover_req` rises. It stays 1 after the reference recovers, until it is cleared.
- R5: A one on `status_clr` clears `main_ref_failed` at the next edge. If a new holdover entry happens at the same edge, the set wins and the bit stays 1.
- R6: While `holdover_req` is 1 and `reject_alarm` is 0, the first sampled reference pulse clears `holdover_req` at that same edge.
- R7: While `reject_alarm` is 1, reference pulses do not clear `holdover_req`.
- R8: `phase_lost` equals `holdover_req` when `phase_lost_en` is 1, and is 0 when `phase_lost_en` is 0. It follows the enable in the same cycle.
- R9: The gap counter saturates instead of wrapping. A gap of any length keeps `holdover_req` at 1. After a release, the next trip again takes exactly L+2 edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_edge | input | 1 | One-cycle pulse per synchronized reference edge |
| exp_period | input | CNT_W | Expected reference period in system clocks |
| phase_lost_en | input | 1 | Makes the phase-lost output mirror the holdover request |
| reject_alarm | input | 1 | Rejection alarm from the slow activity/frequency monitor |
| status_clr | input | 1 | Write-one-to-clear strobe for the failure status |
| main_ref_failed | output | 1 | Sticky record of a holdover entry |
| holdover_req | output | 1 | Request to freeze the loop in holdover |
| phase_lost | output | 1 | Phase-lost indication |

## Verification
Directed gaps of exactly L+1 and L+2 idle edges pin the trip point to a single cycle. Pulses spaced exactly at the limit show that the boundary does not trip. Recovery is run once with the rejection alarm high and once with it low, to separate a release from a held request. A clear that coincides with a new trip shows whether set or clear has priority. A gap of several hundred cycles exercises counter saturation. Randomly varied periods, gaps, alarms and clears are then compared cycle by cycle against a bench model built from the requirements.

// File: rtl/refclk_gap_guard.sv
module refclk_gap_guard #(
  parameter int CNT_W  = 16,
  parameter int MARGIN = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_edge,
  input  logic [CNT_W-1:0] exp_period,
  input  logic             phase_lost_en,
  input  logic             reject_alarm,
  input  logic             status_clr,
  output logic             main_ref_failed,
  output logic             holdover_req,
  output logic             phase_lost
);
  localparam int GW = CNT_W + 2;

  logic [GW-1:0] gap_cnt;
  logic [GW-1:0] gap_limit;
  logic          gap_over;
  logic          release_ok;

  assign gap_limit  = GW'({1'b0, exp_period, 1'b0}) + GW'(MARGIN);
  assign gap_over   = (gap_cnt > gap_limit) && !ref_edge;
  assign release_ok = ref_edge && !reject_alarm;
  assign phase_lost = holdover_req & phase_lost_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_cnt         <= '0;
      holdover_req    <= 1'b0;
      main_ref_failed <= 1'b0;
    end else begin
      if (ref_edge)       gap_cnt <= '0;
      else if (!(&gap_cnt)) gap_cnt <= gap_cnt + 1'b1;

      if (gap_over)        holdover_req <= 1'b1;
      else if (release_ok) holdover_req <= 1'b0;

      if (gap_over && !holdover_req) main_ref_failed <= 1'b1;
      else if (status_clr)           main_ref_failed <= 1'b0;
    end
  end

  assert_trip_needs_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(holdover_req) |-> $past(!ref_edge));
  assert_edge_blocks_trip_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_edge && !holdover_req) |=> !holdover_req);
  assert_entry_recorded_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(holdover_req) |-> main_ref_failed);
  assert_sticky_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (main_ref_failed && !status_clr) |=> main_ref_failed);
  assert_release_on_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (holdover_req && ref_edge && !reject_alarm) |=> !holdover_req);
  assert_alarm_keeps_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (holdover_req && reject_alarm) |=> holdover_req);
endmodule

// File: tb/refclk_gap_guard_bench.sv
module refclk_gap_guard_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 6;
  localparam int MARGIN = 2;
  localparam int CMAX = (1 << (CNT_W + 2)) - 1;

  logic clk = 0, rst_n = 0, ref_edge = 0, phase_lost_en = 0, reject_alarm = 0, status_clr = 0;
  logic [CNT_W-1:0] exp_period = 5;
  logic main_ref_failed, holdover_req, phase_lost;

  int nchk = 0, nfail = 0;
  int mcnt = 0;
  bit mhold = 0, msticky = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  refclk_gap_guard #(.CNT_W(CNT_W), .MARGIN(MARGIN)) u_refclk_gap_guard (
    .clk(clk), .rst_n(rst_n), .ref_edge(ref_edge), .exp_period(exp_period),
    .phase_lost_en(phase_lost_en), .reject_alarm(reject_alarm), .status_clr(status_clr),
    .main_ref_failed(main_ref_failed), .holdover_req(holdover_req), .phase_lost(phase_lost));

  function automatic int lim_of(int p);
    return 2 * p + MARGIN;
  endfunction

  function automatic bit exp_phase(bit h, bit en);
    return h && en;
  endfunction

  task automatic check(string tag, int act, int expv);
    nchk++;
    if (act !== expv) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic tick();
    bit over;
    @(posedge clk);
    if (!rst_n) begin
      mcnt = 0; mhold = 0; msticky = 0;
    end else begin
      over = (mcnt > lim_of(int'(exp_period))) && !ref_edge;
      if (over && !mhold) msticky = 1; else if (status_clr) msticky = 0;
      if (over) mhold = 1; else if (ref_edge && !reject_alarm) mhold = 0;
      if (ref_edge) mcnt = 0; else if (mcnt < CMAX) mcnt++;
    end
    @(negedge clk);
    check("R2 holdover_req model", int'(holdover_req), int'(mhold));
    check("R4 main_ref_failed model", int'(main_ref_failed), int'(msticky));
    check("R8 phase_lost model", int'(phase_lost), int'(exp_phase(mhold, phase_lost_en)));
  endtask

  task automatic idle(int n);
    ref_edge = 0;
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic pulse();
    ref_edge = 1; tick(); ref_edge = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nfail++; nchk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    int L;
    int gap;
    int nxt;
    void'($urandom(1234));
    @(negedge clk);
    rst_n = 0; tick(); tick();
    check("R1 holdover after reset", int'(holdover_req), 0);
    check("R1 status after reset", int'(main_ref_failed), 0);
    check("R1 phase_lost after reset", int'(phase_lost), 0);
    rst_n = 1;
    exp_period = 5; L = lim_of(5);
    pulse();
    idle(L + 1);
    check("R3 no trip after L+1 idle edges", int'(holdover_req), 0);
    idle(1);
    check("R2 trip at L+2", int'(holdover_req), 1);
    check("R4 sticky set on entry", int'(main_ref_failed), 1);
    check("R8 phase_lost gated off", int'(phase_lost), 0);
    phase_lost_en = 1; #1;
    check("R8 phase_lost follows enable", int'(phase_lost), 1);
    reject_alarm = 1; pulse();
    check("R7 alarm keeps holdover", int'(holdover_req), 1);
    reject_alarm = 0; pulse();
    check("R6 release on first edge", int'(holdover_req), 0);
    check("R4 sticky survives recovery", int'(main_ref_failed), 1);
    status_clr = 1; tick(); status_clr = 0;
    check("R5 clear by write one", int'(main_ref_failed), 0);
    for (int k = 0; k < 4; k++) begin
      idle(L + 1); pulse();
      check("R3 spacing L+2 no trip", int'(holdover_req), 0);
    end
    idle(L + 1);
    status_clr = 1; tick(); status_clr = 0;
    check("R5 set wins over clear", int'(main_ref_failed), 1);
    check("R2 trip at coinciding clear", int'(holdover_req), 1);
    idle(400);
    check("R9 long gap keeps holdover", int'(holdover_req), 1);
    pulse();
    check("R9 release after saturation", int'(holdover_req), 0);
    idle(L + 1);
    check("R9 no early trip after release", int'(holdover_req), 0);
    idle(1);
    check("R9 retrip at L+2", int'(holdover_req), 1);
    pulse();
    nxt = 5;
    for (int c = 0; c < 4000; c++) begin
      if ($urandom_range(0, 199) == 0) exp_period = CNT_W'($urandom_range(3, 30));
      if ($urandom_range(0, 99) == 0) reject_alarm = !reject_alarm;
      if ($urandom_range(0, 149) == 0) phase_lost_en = !phase_lost_en;
      status_clr = ($urandom_range(0, 39) == 0);
      nxt--;
      if (nxt <= 0) begin
        ref_edge = 1;
        gap = int'(exp_period);
        nxt = ($urandom_range(0, 4) == 0) ? $urandom_range(1, 3 * gap + 8) : gap;
      end else ref_edge = 0;
      tick();
    end
    status_clr = 0; ref_edge = 0;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule